// File: doc/BRIEF.md
# Program/Data Bus Width Exchanger

This block links a 24-bit program-memory data path to a 16-bit data-memory data path without losing data. An 8-bit side register, here called the spill byte, holds the part of a wide word that does not fit on the narrow path.

When a wide word is read from program memory, its top 16 bits go straight onto the narrow result bus in the same cycle. Its bottom 8 bits are parked in the spill byte at the next clock edge. When a narrow value is written to program memory, the wide write word is built from that value in the top 16 bits and the spill byte in the bottom 8 bits. Software can also write the spill byte directly from the narrow bus, and read it back zero-extended. Memory arrays and bus arbitration sit outside the block.

Top module: `bus_xchg`

## Requirements
- R1: After reset the spill byte is 0x00, so a direct read returns 0x0000.
- R2: While `pmRdEn` is high, `narrowOut` equals `pmRdData[23:8]` in the same cycle.
- R3: A clock edge with `pmRdEn` high loads `pmRdData[7:0]` into the spill byte.
- R4: `pmWrData[23:8]` always equals `narrowIn`, and `pmWrData[7:0]` always equals the current spill byte.
- R5: A clock edge with `pxWrEn` high and `pmRdEn` low loads `narrowIn[7:0]` into the spill byte. `narrowIn[15:8]` is discarded.
- R6: While `pxRdEn` is high and `pmRdEn` is low, `narrowOut` equals `{8'h00, spill byte}`.
- R7: A clock edge with both `pmRdEn` and `pxWrEn` low leaves the spill byte unchanged.
- R8: When `pmRdEn` and `pxWrEn` are both high at an edge, the spill byte takes `pmRdData[7:0]` and the direct write is ignored.
- R9: When `pmRdEn` and `pxRdEn` are both high, `narrowOut` carries `pmRdData[23:8]`.
- R10: While `pmRdEn` and `pxRdEn` are both low, `narrowOut` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pmRdEn | input | 1 | A program-memory word is being read into a narrow register |
| pmRdData | input | 24 | Wide word read from program memory |
| pxWrEn | input | 1 | Direct write of the spill byte from the narrow bus |
| pxRdEn | input | 1 | Direct read of the spill byte onto the narrow bus |
| narrowIn | input | 16 | Narrow register value, used for wide writes and direct spill writes |
| narrowOut | output | 16 | Narrow result: upper wide bits, zero-extended spill byte, or zero |
| pmWrData | output | 24 | Wide word assembled for a program-memory write |

## Verification
`narrowOut` and `pmWrData` are combinational, so they are due in the same cycle as their inputs. The spill byte changes one edge after the strobe that loads it, and that change can only be seen through those two outputs. The bench drives inputs on the falling edge, compares the outputs a short delay later against a bench model of the spill byte, and only updates that model at the following rising edge. A load is therefore first checked in the cycle after its edge.

// File: rtl/bus_xchg_pkg.sv
package bus_xchg_pkg;
  typedef struct packed {
    logic takeWide;    // load spill byte from wide read
    logic takeNarrow;  // load spill byte from narrow bus
    logic showWide;    // drive upper wide bits on narrow output
    logic showSpill;   // drive zero-extended spill byte on narrow output
  } xchgStrobes_t;
endpackage

// File: rtl/bus_xchg_ctrl.sv
module bus_xchg_ctrl
  import bus_xchg_pkg::*;
(
  input  logic         pmRdEn,
  input  logic         pxWrEn,
  input  logic         pxRdEn,
  output xchgStrobes_t strobes
);
  always_comb begin
    strobes            = '0;
    strobes.takeWide   = pmRdEn;
    strobes.takeNarrow = pxWrEn & ~pmRdEn;
    strobes.showWide   = pmRdEn;
    strobes.showSpill  = pxRdEn & ~pmRdEn;
  end
endmodule

// File: rtl/bus_xchg_dp.sv
module bus_xchg_dp
  import bus_xchg_pkg::*;
#(
  parameter int WIDE_W   = 24,
  parameter int NARROW_W = 16,
  localparam int SPILL_W = WIDE_W - NARROW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  xchgStrobes_t        strobes,
  input  logic [WIDE_W-1:0]   pmRdData,
  input  logic [NARROW_W-1:0] narrowIn,
  output logic [NARROW_W-1:0] narrowOut,
  output logic [WIDE_W-1:0]   pmWrData,
  output logic [SPILL_W-1:0]  spillQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   spillQ <= '0;
    else if (strobes.takeWide)   spillQ <= pmRdData[SPILL_W-1:0];
    else if (strobes.takeNarrow) spillQ <= narrowIn[SPILL_W-1:0];
  end

  always_comb begin
    if (strobes.showWide)       narrowOut = pmRdData[WIDE_W-1:SPILL_W];
    else if (strobes.showSpill) narrowOut = {{(NARROW_W-SPILL_W){1'b0}}, spillQ};
    else                        narrowOut = '0;
  end

  assign pmWrData = {narrowIn, spillQ};
endmodule

// File: rtl/bus_xchg.sv
module bus_xchg
  import bus_xchg_pkg::*;
#(
  parameter int WIDE_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pmRdEn,
  input  logic [WIDE_W-1:0]   pmRdData,
  input  logic                pxWrEn,
  input  logic                pxRdEn,
  input  logic [NARROW_W-1:0] narrowIn,
  output logic [NARROW_W-1:0] narrowOut,
  output logic [WIDE_W-1:0]   pmWrData
);
  localparam int SPILL_W = WIDE_W - NARROW_W;

  xchgStrobes_t       strobes;
  logic [SPILL_W-1:0] spillQ;

  bus_xchg_ctrl uCtrl (
    .pmRdEn (pmRdEn),
    .pxWrEn (pxWrEn),
    .pxRdEn (pxRdEn),
    .strobes(strobes)
  );

  bus_xchg_dp #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pmRdData (pmRdData),
    .narrowIn (narrowIn),
    .narrowOut(narrowOut),
    .pmWrData (pmWrData),
    .spillQ   (spillQ)
  );
endmodule

// File: rtl/bus_xchg_chk.sv
module bus_xchg_chk #(
  parameter int WIDE_W   = 24,
  parameter int NARROW_W = 16,
  localparam int SPILL_W = WIDE_W - NARROW_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                pmRdEn,
  input logic [WIDE_W-1:0]   pmRdData,
  input logic                pxWrEn,
  input logic                pxRdEn,
  input logic [NARROW_W-1:0] narrowIn,
  input logic [NARROW_W-1:0] narrowOut,
  input logic [WIDE_W-1:0]   pmWrData,
  input logic [SPILL_W-1:0]  spillQ
);
  // R2, R9
  wide_read_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmRdEn |-> narrowOut == pmRdData[WIDE_W-1:SPILL_W]);

  // R3, R8
  wide_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmRdEn |=> spillQ == $past(pmRdData[SPILL_W-1:0]));

  // R4
  wide_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmWrData == {narrowIn, spillQ});

  // R5
  narrow_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pxWrEn && !pmRdEn) |=> spillQ == $past(narrowIn[SPILL_W-1:0]));

  // R6
  spill_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pxRdEn && !pmRdEn) |-> narrowOut == {{(NARROW_W-SPILL_W){1'b0}}, spillQ});

  // R7
  spill_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pxWrEn && !pmRdEn) |=> $stable(spillQ));

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pxRdEn && !pmRdEn) |-> narrowOut == '0);
endmodule

bind bus_xchg bus_xchg_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) uChk (
  .clk(clk), .rstN(rstN), .pmRdEn(pmRdEn), .pmRdData(pmRdData),
  .pxWrEn(pxWrEn), .pxRdEn(pxRdEn), .narrowIn(narrowIn),
  .narrowOut(narrowOut), .pmWrData(pmWrData), .spillQ(spillQ)
);

// File: tb/bus_xchg_test.sv
`timescale 1ns/1ps
module bus_xchg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pmRdEn = 1'b0, pxWrEn = 1'b0, pxRdEn = 1'b0;
  logic [23:0] pmRdData = '0;
  logic [15:0] narrowIn = '0;
  logic [15:0] narrowOut;
  logic [23:0] pmWrData;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_xchg uut (
    .clk(clk), .rstN(rstN), .pmRdEn(pmRdEn), .pmRdData(pmRdData),
    .pxWrEn(pxWrEn), .pxRdEn(pxRdEn), .narrowIn(narrowIn),
    .narrowOut(narrowOut), .pmWrData(pmWrData)
  );

  function automatic logic [15:0] expNarrow(logic rd, logic sr, logic [23:0] w, logic [7:0] m);
    if (rd)      return w[23:8];
    else if (sr) return {8'h00, m};
    else         return 16'h0000;
  endfunction

  function automatic logic [7:0] nextModel(logic rd, logic wr, logic [23:0] w,
                                           logic [15:0] n, logic [7:0] m);
    if (rd)      return w[7:0];
    else if (wr) return n[7:0];
    else         return m;
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  string tagN, tagW;
  task automatic step(logic rd, logic wr, logic sr, logic [23:0] w, logic [15:0] n);
    @(negedge clk);
    pmRdEn = rd; pxWrEn = wr; pxRdEn = sr; pmRdData = w; narrowIn = n;
    #1;
    tagN = rd ? (sr ? "R9" : "R2") : (sr ? "R6" : "R10");
    check(tagN, {8'h00, narrowOut}, {8'h00, expNarrow(rd, sr, w, model)});
    check("R4", pmWrData, {n, model});
    @(posedge clk);
    model = nextModel(rd, wr, w, n, model);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (2) @(posedge clk);
    #1;
    // R1: spill byte clear after reset
    @(negedge clk); rstN = 1'b1; pxRdEn = 1'b1; #1;
    check("R1", {8'h00, narrowOut}, 24'h0);
    check("R1", pmWrData[7:0], 8'h00);
    // R3: wide read captures low byte
    step(1, 0, 0, 24'hABCD5A, 16'h0000);
    step(0, 0, 1, 24'h000000, 16'h1111);
    // R5: direct write keeps only low byte
    step(0, 1, 0, 24'h000000, 16'hFFC3);
    step(0, 0, 1, 24'h000000, 16'h0000);
    // R8: wide read beats direct write
    step(1, 1, 0, 24'h123477, 16'h00EE);
    tagW = "R8";
    @(negedge clk); pmRdEn = 0; pxWrEn = 0; pxRdEn = 1; #1;
    check(tagW, {8'h00, narrowOut}, 24'h000077);
    // R7: hold across idle cycles
    step(0, 0, 0, 24'hFFFFFF, 16'hBEEF);
    step(0, 0, 0, 24'h000000, 16'h0000);
    step(0, 0, 1, 24'h000000, 16'h0000);
    // R9: both reads, wide bits win
    step(1, 0, 1, 24'hC0FFEE, 16'h0000);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
           24'($urandom), 16'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule